// File: doc/BRIEF.md
# Ethernet Transmit Packet Framer

This block turns a client frame into a byte-wide transmit packet for a gigabit media-independent interface. The client supplies the frame as a byte stream that starts at the destination address and ends at the last payload byte. The framer adds everything else around that stream. It puts a preamble and a start delimiter in front. It fills short frames with zero bytes up to the minimum size. It computes the 32-bit frame check sequence and appends it. It then holds the line idle for the minimum interpacket gap. The transmit side has three outputs: a data byte, an enable and an error flag. All three are registered.

The client port is valid/ready. A byte moves only on a clock edge where both `in_valid` and `in_ready` are high. `in_last` marks the final client byte and is taken together with that byte. A frame starts when `in_valid` is seen while the framer is idle. `in_ready` is raised only while the framer is taking client bytes. It stays low through the preamble, start delimiter, padding, check sequence and gap. The client may hold `in_valid` high while `in_ready` is low; the byte and `in_last` must then stay stable until the transfer happens. Dropping `in_valid` in the middle of a frame is an underrun. The packet goes on, but it is marked bad.

Multi-byte fields such as length/type are sent in the order the client gives them. That order is most significant byte first.

Top module: `eth_tx_framer`

## Requirements
- R1: While reset is asserted and until the first frame starts, `gmii_tx_en`, `gmii_tx_er` and `in_ready` are 0 and `gmii_txd` is 0x00.
- R2: Every packet begins with seven bytes of 0x55 and then one byte of 0xD5, all with `gmii_tx_en` high. The first client byte follows on the next cycle.
- R3: `in_ready` is high only while client bytes are being taken, never while `gmii_tx_en` is low. When the framer is idle and the client raises `in_valid`, `in_ready` first goes high after exactly 9 clock cycles.
- R4: Each accepted client byte appears on `gmii_txd` with `gmii_tx_en` high one cycle after its transfer edge. Bytes keep their order.
- R5: When the client part has fewer than 60 bytes, zero bytes follow it until it reaches 60 bytes. A client part of 60 bytes or more gets no padding.
- R6: The 4 bytes after the client part and padding are the inverted CRC-32, least significant byte first, with no bit reversal inside a byte. The CRC is the reflected generator 0xEDB88320, seeded with all ones, and fed each byte into its low bits. It covers the client bytes and the padding only. For the 42-byte broadcast ARP frame used in the bench, the four bytes are 69 70 39 BB.
- R7: At least 12 idle cycles separate the last check byte of one packet from the first preamble byte of the next. If the next frame is already waiting, the gap is exactly 12.
- R8: An underrun is a cycle in the client phase where `in_valid` is low. For each such cycle the framer sends a filler byte 0x00 with `gmii_tx_en` and `gmii_tx_er` high. From then on `gmii_tx_er` stays high through the last check byte. Filler bytes do not count toward the length and do not enter the CRC. `gmii_tx_er` is never high while `gmii_tx_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Client frame byte |
| in_valid | input | 1 | Client byte is present |
| in_last | input | 1 | Client byte is the final byte of the frame |
| in_ready | output | 1 | Framer accepts the client byte on this edge |
| gmii_txd | output | 8 | Transmit data byte |
| gmii_tx_en | output | 1 | Transmit data is part of a packet |
| gmii_tx_er | output | 1 | Packet is corrupt (underrun) |

## Verification
Each client byte is due on the transmit outputs exactly one cycle after its transfer edge. The 60th body byte is due right after the last client byte or the last pad byte, with the first check byte on the following cycle. The first `in_ready` is due 9 cycles after `in_valid` rises on an idle framer. The next preamble is due exactly 12 idle cycles after a final check byte when a frame is waiting. The bench drives inputs and samples outputs on the falling edge. It records every enabled byte in transmit order. It compares the record to a packet built from the requirements, with its own CRC, so any byte that arrives early, late or twice shifts the record and is reported.

// File: rtl/eth_txf_pkg.sv
package eth_txf_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_PRE,
    S_SFD,
    S_DATA,
    S_PAD,
    S_FCS,
    S_GAP
  } txf_state_e;

  localparam logic [7:0]  PRE_BYTE     = 8'h55;
  localparam logic [7:0]  SFD_BYTE     = 8'hD5;
  localparam int          FCS_LEN      = 4;
  localparam logic [31:0] CRC_POLY_LSB = 32'hEDB88320;
endpackage

// File: rtl/txf_crc.sv
module txf_crc #(
  parameter int             W    = 32,
  parameter int             DW   = 8,
  parameter logic [W-1:0]   POLY = 32'hEDB88320
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init,
  input  logic          en,
  input  logic [DW-1:0] din,
  output logic [W-1:0]  crc
);
  logic [W-1:0] crc_q;
  logic [W-1:0] crc_nx;

  // reflected update: byte enters the low bits, register shifts right
  always_comb begin
    crc_nx = crc_q ^ {{(W-DW){1'b0}}, din};
    for (int b = 0; b < DW; b++) begin
      crc_nx = crc_nx[0] ? ((crc_nx >> 1) ^ POLY) : (crc_nx >> 1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || init) crc_q <= '1;
    else if (en)        crc_q <= crc_nx;
  end

  assign crc = crc_q;

  // R6: the accumulator moves only when fed or reseeded
  assert_crc_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && !en) |=> $stable(crc_q));
endmodule

// File: rtl/txf_ctr.sv
module txf_ctr #(
  parameter  int MAX = 15,
  localparam int W   = $clog2(MAX + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr)              q <= '0;
    else if (inc && q != W'(MAX))   q <= q + 1'b1;
  end
endmodule

// File: rtl/eth_tx_framer.sv
module eth_tx_framer #(
  parameter int PRE_LEN   = 7,
  parameter int MIN_FRAME = 64,
  parameter int IPG_LEN   = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  input  logic       in_last,
  output logic       in_ready,
  output logic [7:0] gmii_txd,
  output logic       gmii_tx_en,
  output logic       gmii_tx_er
);
  import eth_txf_pkg::*;

  localparam int BODY_MIN = MIN_FRAME - FCS_LEN;
  localparam int PH_MAX   = (PRE_LEN > IPG_LEN) ? PRE_LEN : IPG_LEN;
  localparam int PH_W     = $clog2(PH_MAX + 1);
  localparam int LEN_W    = $clog2(BODY_MIN + 1);
  localparam int GAP_W    = $clog2(IPG_LEN + 1);

  txf_state_e st, st_nx;
  logic [PH_W-1:0]  ph_cnt;
  logic [LEN_W-1:0] len_cnt;
  logic ph_clr, ph_inc, len_clr, len_inc;
  logic crc_init, crc_en;
  logic [7:0]  crc_din;
  logic [31:0] crc_q, fcs_word;
  logic err_q, err_set, err_clr;
  logic [7:0] nx_d;
  logic nx_en, nx_er;

  // phase counter: preamble bytes, check bytes, gap bytes
  txf_ctr #(.MAX(PH_MAX)) u_phase (
    .clk(clk), .rst_n(rst_n), .clr(ph_clr), .inc(ph_inc), .q(ph_cnt));

  // body length counter, saturating at the minimum body size
  txf_ctr #(.MAX(BODY_MIN)) u_len (
    .clk(clk), .rst_n(rst_n), .clr(len_clr), .inc(len_inc), .q(len_cnt));

  txf_crc #(.W(32), .DW(8), .POLY(CRC_POLY_LSB)) u_crc (
    .clk(clk), .rst_n(rst_n), .init(crc_init), .en(crc_en),
    .din(crc_din), .crc(crc_q));

  assign fcs_word = ~crc_q;
  assign in_ready = (st == S_DATA);

  always_comb begin
    st_nx    = st;
    ph_clr   = 1'b0;
    ph_inc   = 1'b0;
    len_clr  = 1'b0;
    len_inc  = 1'b0;
    crc_init = 1'b0;
    crc_en   = 1'b0;
    crc_din  = in_data;
    err_set  = 1'b0;
    err_clr  = 1'b0;
    nx_d     = 8'h00;
    nx_en    = 1'b0;
    nx_er    = 1'b0;
    unique case (st)
      S_IDLE: begin
        if (in_valid) begin
          st_nx  = S_PRE;
          ph_clr = 1'b1;
        end
      end
      S_PRE: begin
        nx_en  = 1'b1;
        nx_d   = PRE_BYTE;
        ph_inc = 1'b1;
        if (ph_cnt == PH_W'(PRE_LEN - 1)) st_nx = S_SFD;
      end
      S_SFD: begin
        nx_en    = 1'b1;
        nx_d     = SFD_BYTE;
        crc_init = 1'b1;
        len_clr  = 1'b1;
        err_clr  = 1'b1;
        st_nx    = S_DATA;
      end
      S_DATA: begin
        nx_en = 1'b1;
        if (in_valid) begin
          nx_d    = in_data;
          nx_er   = err_q;
          crc_en  = 1'b1;
          len_inc = 1'b1;
          if (in_last) begin
            ph_clr = 1'b1;
            st_nx  = (len_cnt >= LEN_W'(BODY_MIN - 1)) ? S_FCS : S_PAD;
          end
        end else begin
          nx_d    = 8'h00;
          nx_er   = 1'b1;
          err_set = 1'b1;
        end
      end
      S_PAD: begin
        nx_en   = 1'b1;
        nx_er   = err_q;
        crc_en  = 1'b1;
        crc_din = 8'h00;
        len_inc = 1'b1;
        if (len_cnt == LEN_W'(BODY_MIN - 1)) begin
          st_nx  = S_FCS;
          ph_clr = 1'b1;
        end
      end
      S_FCS: begin
        nx_en  = 1'b1;
        nx_er  = err_q;
        nx_d   = fcs_word[{ph_cnt[1:0], 3'b000} +: 8];
        ph_inc = 1'b1;
        if (ph_cnt == PH_W'(FCS_LEN - 1)) begin
          st_nx  = S_GAP;
          ph_clr = 1'b1;
        end
      end
      S_GAP: begin
        ph_inc = 1'b1;
        // the idle-state cycle supplies the last gap byte
        if (ph_cnt == PH_W'(IPG_LEN - 2)) st_nx = S_IDLE;
      end
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      err_q      <= 1'b0;
      gmii_txd   <= 8'h00;
      gmii_tx_en <= 1'b0;
      gmii_tx_er <= 1'b0;
    end else begin
      st         <= st_nx;
      gmii_txd   <= nx_d;
      gmii_tx_en <= nx_en;
      gmii_tx_er <= nx_er;
      if (err_clr)      err_q <= 1'b0;
      else if (err_set) err_q <= 1'b1;
    end
  end

  // idle-run observer for the gap check
  logic [GAP_W-1:0] idle_run;
  always_ff @(posedge clk) begin
    if (!rst_n)                            idle_run <= GAP_W'(IPG_LEN);
    else if (gmii_tx_en)                   idle_run <= '0;
    else if (idle_run != GAP_W'(IPG_LEN))  idle_run <= idle_run + 1'b1;
  end

  assert_pre_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gmii_tx_en) |-> gmii_txd == 8'h55);

  assert_ready_in_pkt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> gmii_tx_en);

  assert_byte_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (gmii_tx_en && gmii_txd == $past(in_data)));

  assert_min_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gmii_tx_en) |-> idle_run >= GAP_W'(IPG_LEN));

  assert_er_needs_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
    gmii_tx_er |-> gmii_tx_en);
endmodule

// File: tb/eth_tx_framer_tb_top.sv
`timescale 1ns/1ps
module eth_tx_framer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_valid = 1'b0;
  logic       in_last = 1'b0;
  logic       in_ready;
  logic [7:0] gmii_txd;
  logic       gmii_tx_en;
  logic       gmii_tx_er;

  always #2.5 clk = ~clk;

  eth_tx_framer dut_i (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_last(in_last), .in_ready(in_ready), .gmii_txd(gmii_txd),
    .gmii_tx_en(gmii_tx_en), .gmii_tx_er(gmii_tx_er));

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // frame under test
  logic [7:0] fr [0:127];
  int fr_n = 0;
  int first_wait = 0;

  // monitor: record every enabled byte, measure gaps
  logic [7:0] cap_d [0:255];
  logic       cap_e [0:255];
  int cap_n = 0;
  int idle_run = 100;
  int gap_seen = -1;
  int rdy_idle = 0;
  logic prev_en = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (in_ready && !gmii_tx_en) rdy_idle++;
      if (gmii_tx_en) begin
        if (!prev_en) gap_seen = idle_run;
        if (cap_n < 256) begin
          cap_d[cap_n] = gmii_txd;
          cap_e[cap_n] = gmii_tx_er;
        end
        cap_n++;
        idle_run = 0;
      end else begin
        idle_run++;
      end
      prev_en = gmii_tx_en;
    end
  end

  // len, seed, step
  localparam int VEC [6][3] = '{
    '{1,  8'h3C, 1},
    '{14, 8'hA5, 7},
    '{59, 8'h00, 3},
    '{60, 8'hFF, 255},
    '{61, 8'h11, 13},
    '{75, 8'h80, 5}
  };

  localparam logic [7:0] ARP [42] = '{
    8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hF8, 8'hB7, 8'hE2, 8'h04,
    8'h0C, 8'h19, 8'h08, 8'h06, 8'h00, 8'h01, 8'h08, 8'h00, 8'h06, 8'h04,
    8'h00, 8'h01, 8'hF8, 8'hB7, 8'hE2, 8'h04, 8'h0C, 8'h19, 8'h44, 8'h0F,
    8'h43, 8'hF1, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h44, 8'h0F,
    8'h43, 8'hFE};

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'h0, d};
    for (int b = 0; b < 8; b++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  // drive the frame; hole_len cycles of underrun inserted before byte hole_at
  task automatic send_frame(input int hole_at, input int hole_len);
    int i = 0;
    int left = hole_len;
    bit rdy;
    first_wait = 0;
    while (i < fr_n) begin
      @(negedge clk);
      if (i == hole_at && left > 0 && in_ready) begin
        in_valid = 1'b0;
        in_last  = 1'b0;
        left--;
        @(posedge clk);
      end else begin
        in_valid = 1'b1;
        in_data  = fr[i];
        in_last  = (i == fr_n - 1);
        rdy = in_ready;
        if (i == 0 && !rdy) first_wait++;
        @(posedge clk);
        if (rdy) i++;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic wait_pkt_end();
    do @(negedge clk); while (gmii_tx_en);
    @(negedge clk);
  endtask

  // build the expected packet from the requirements and compare
  task automatic check_pkt(input int hole_at, input int hole_len, input string tag);
    logic [7:0] ed [0:255];
    logic       ee [0:255];
    int n = 0;
    int body_n;
    int bad_pre = 0, bad_body = 0, bad_fcs = 0, bad_er = 0;
    int first_bad = -1;
    logic [31:0] c = 32'hFFFFFFFF;
    logic [7:0] b;
    body_n = (fr_n < 60) ? 60 : fr_n;
    for (int k = 0; k < 7; k++) begin ed[n] = 8'h55; ee[n] = 1'b0; n++; end
    ed[n] = 8'hD5; ee[n] = 1'b0; n++;
    for (int k = 0; k < body_n; k++) begin
      if (k == hole_at) begin
        for (int h = 0; h < hole_len; h++) begin ed[n] = 8'h00; ee[n] = 1'b1; n++; end
      end
      b = (k < fr_n) ? fr[k] : 8'h00;
      c = crc_step(c, b);
      ed[n] = b;
      ee[n] = (hole_len > 0 && k >= hole_at);
      n++;
    end
    c = ~c;
    for (int k = 0; k < 4; k++) begin ed[n] = c[8*k +: 8]; ee[n] = (hole_len > 0); n++; end
    chk(cap_n == n, "R5", {tag, " packet length"}, cap_n, n);
    for (int k = 0; k < n && k < cap_n; k++) begin
      if (cap_d[k] !== ed[k]) begin
        if (first_bad < 0) first_bad = k;
        if (k < 8) bad_pre++;
        else if (k >= n - 4) bad_fcs++;
        else bad_body++;
      end
      if (cap_e[k] !== ee[k]) bad_er++;
    end
    chk(bad_pre == 0, "R2", {tag, " preamble mismatches"}, bad_pre, 0);
    chk(bad_body == 0, "R4", {tag, " body/pad mismatches"}, bad_body, 0);
    chk(bad_fcs == 0, "R6", {tag, " check byte mismatches"}, bad_fcs, 0);
    chk(bad_er == 0, "R8", {tag, " error flag mismatches"}, bad_er, 0);
    if (first_bad >= 0)
      $display("  first differing byte %0d: got %0h want %0h", first_bad,
               cap_d[first_bad], ed[first_bad]);
  endtask

  initial begin
    #500000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!gmii_tx_en && !gmii_tx_er && !in_ready && gmii_txd == 8'h00, "R1",
        "outputs in reset", {gmii_tx_en, gmii_tx_er, in_ready}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!gmii_tx_en && !gmii_tx_er && !in_ready, "R1", "outputs after reset",
        {gmii_tx_en, gmii_tx_er, in_ready}, 0);

    // table walk
    for (int v = 0; v < 6; v++) begin
      fr_n = VEC[v][0];
      for (int i = 0; i < fr_n; i++) fr[i] = 8'(VEC[v][1] + VEC[v][2] * i);
      cap_n = 0;
      send_frame(-1, 0);
      chk(first_wait == 9, "R3", "cycles to first ready", first_wait, 9);
      wait_pkt_end();
      check_pkt(-1, 0, $sformatf("vec%0d", v));
      repeat (15) @(negedge clk);
    end

    // R6: captured broadcast ARP frame
    fr_n = 42;
    for (int i = 0; i < 42; i++) fr[i] = ARP[i];
    cap_n = 0;
    send_frame(-1, 0);
    wait_pkt_end();
    check_pkt(-1, 0, "arp");
    chk({cap_d[68], cap_d[69], cap_d[70], cap_d[71]} == 32'h697039BB, "R6",
        "arp check bytes", {cap_d[68], cap_d[69], cap_d[70], cap_d[71]}, 32'h697039BB);
    chk(cap_d[50] == 8'h00 && cap_d[67] == 8'h00, "R5", "arp pad zero",
        {cap_d[50], cap_d[67]}, 0);
    repeat (15) @(negedge clk);

    // R7: back-to-back frames, next one waiting
    fr_n = 20;
    for (int i = 0; i < fr_n; i++) fr[i] = 8'(i * 9 + 1);
    cap_n = 0;
    send_frame(-1, 0);
    gap_seen = -1;
    send_frame(-1, 0);
    chk(first_wait > 9, "R3", "ready held off during pad/check/gap", first_wait, 10);
    chk(gap_seen == 12, "R7", "idle bytes between packets", gap_seen, 12);
    wait_pkt_end();
    repeat (15) @(negedge clk);

    // R8: underrun of 2 cycles before byte 5
    fr_n = 20;
    for (int i = 0; i < fr_n; i++) fr[i] = 8'(8'hC0 ^ i);
    cap_n = 0;
    send_frame(5, 2);
    wait_pkt_end();
    check_pkt(5, 2, "underrun");
    repeat (15) @(negedge clk);

    // R8: clean frame after underrun carries no error
    fr_n = 61;
    for (int i = 0; i < fr_n; i++) fr[i] = 8'(i);
    cap_n = 0;
    send_frame(-1, 0);
    wait_pkt_end();
    check_pkt(-1, 0, "post-underrun");

    // R3: ready never high outside a packet
    chk(rdy_idle == 0, "R3", "ready while line idle", rdy_idle, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule